// File: doc/BRIEF.md
# Tagged Detection Timestamp Queue

This block sits beside a receive-side frame builder. A free-running 64-bit sample-time counter is fed in alongside three single-cycle detection strobes: a preamble correlator hit, an energy rising edge and an energy falling edge. In any cycle where one or more strobes are high, the block captures the time value. It overwrites the top four bits with a detection-type code and pushes the resulting word into a 16-entry queue. A depth of 16 lets the block absorb bursts of detections that arrive only 10 to 20 samples apart, which can happen many times between two outgoing frames.

The framer pulses a frame-start input once per outgoing frame. On each pulse the oldest queued word is moved into a holding register that feeds the frame's timestamp field, and a valid flag marks it as new. Successive frames therefore carry the queued detections in arrival order. When the queue is empty at a frame start, the previous word is repeated with the valid flag low, so a consumer that watches for changes sees no new event. A detection that finds the queue full is lost, and a sticky overflow flag reports the loss. A debug vector reads all ones while the queue is full and all zeros otherwise.

Top module: `det_ts_queue`

## Requirements
- R1: When any detection strobe is high at a rising clock edge, bits 59:0 of the queued word equal bits 59:0 of the time input sampled at that edge.
- R2: The type code in the queued word is bit 61 for a correlator hit, bit 62 for an energy rising edge and bit 63 for an energy falling edge. Strobes high in the same cycle set all of their bits in a single entry.
- R3: Bit 60 of every emitted word is zero, whatever the time input holds in its top bits.
- R4: A frame-start pulse that finds the queue non-empty loads the oldest entry into the timestamp output in the next cycle and sets the valid flag. Entries leave in arrival order. The output and the valid flag change only on frame-start pulses.
- R5: The queue holds 16 entries without loss, and all 16 are later emitted intact.
- R6: The debug vector is all ones while 16 entries are held and all zeros otherwise.
- R7: A detection is dropped when the queue holds 16 entries at that edge, even if a frame-start pulse removes an entry in the same cycle. The overflow flag is set in the next cycle.
- R8: Once set, the overflow flag stays high until reset.
- R9: A frame-start pulse that finds the queue empty clears the valid flag and leaves the timestamp output unchanged. A detection in that same cycle is queued and is emitted by the following frame-start pulse.
- R10: After reset, the timestamp output is zero, and the valid flag, the debug vector and the overflow flag are low, with the queue empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| time_now | input | 64 | Free-running sample-time counter |
| det_corr | input | 1 | Correlator detection strobe |
| det_rise | input | 1 | Energy rising-edge strobe |
| det_fall | input | 1 | Energy falling-edge strobe |
| frame_start | input | 1 | One-cycle pulse from the framer per outgoing frame |
| ts_out | output | 64 | Tagged timestamp for the frame's timestamp field |
| ts_valid | output | 1 | High when ts_out holds a newly dequeued entry |
| full_dbg | output | 8 | All ones when the queue is full, else zeros |
| ovf | output | 1 | Sticky flag: a detection was dropped |

## Verification
Single strobes of each kind show whether each tag bit lands in its own position. A joint strobe shows whether simultaneous events merge into one entry rather than two. The time input carries ones in its top nibble, so a tag that leaves the counter bits in place, or sets bit 60, is caught. A five-event burst drained by five frames checks ordering. Filling to exactly 15 and then 16 entries separates an off-by-one full flag from a correct one. Pushing while full, both with and without a simultaneous frame start, checks the drop rule and the sticky flag. Frame starts on an empty queue, alone and together with a detection, check that the output is repeated with valid low and that the new event waits for the next frame.

// File: rtl/det_ts_pkg.sv
package det_ts_pkg;

  localparam int TS_W     = 64;
  localparam int RSV_BIT  = 60;
  localparam int TIME_W   = 60;

  typedef struct packed {
    logic fall;
    logic rise;
    logic corr;
  } det_kind_t;

  // Build a queue word: three type bits, a zero reserved bit, then time[59:0].
  function automatic logic [TS_W-1:0] build_entry(input logic [TS_W-1:0] t,
                                                   input det_kind_t      k);
    logic [TS_W-1:0] w;
    w = '0;
    w[TIME_W-1:0] = t[TIME_W-1:0];
    w[RSV_BIT]    = 1'b0;
    w[RSV_BIT+1]  = k.corr;
    w[RSV_BIT+2]  = k.rise;
    w[RSV_BIT+3]  = k.fall;
    return w;
  endfunction

  function automatic logic any_event(input det_kind_t k);
    return k.corr | k.rise | k.fall;
  endfunction

endpackage

// File: rtl/ts_capture.sv
module ts_capture
  import det_ts_pkg::*;
(
  input  logic [TS_W-1:0] time_now,
  input  logic            det_corr,
  input  logic            det_rise,
  input  logic            det_fall,
  output logic            push_req,
  output logic [TS_W-1:0] push_word
);
  det_kind_t kind;

  assign kind      = '{fall: det_fall, rise: det_rise, corr: det_corr};
  assign push_req  = any_event(kind);
  assign push_word = build_entry(time_now, kind);
endmodule

// File: rtl/ts_fifo.sv
module ts_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= next_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
      unique case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ts_drain.sv
module ts_drain #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_start,
  input  logic         q_empty,
  input  logic [W-1:0] q_head,
  output logic         pop_req,
  output logic [W-1:0] ts_out,
  output logic         ts_valid
);
  assign pop_req = frame_start && !q_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_out   <= '0;
      ts_valid <= 1'b0;
    end else if (frame_start) begin
      ts_valid <= !q_empty;
      if (!q_empty) ts_out <= q_head;
    end
  end
endmodule

// File: rtl/det_ts_queue.sv
module det_ts_queue
  import det_ts_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DBG_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TS_W-1:0]  time_now,
  input  logic             det_corr,
  input  logic             det_rise,
  input  logic             det_fall,
  input  logic             frame_start,
  output logic [TS_W-1:0]  ts_out,
  output logic             ts_valid,
  output logic [DBG_W-1:0] full_dbg,
  output logic             ovf
);
  logic             push_req;
  logic [TS_W-1:0]  push_word;
  logic             pop_req;
  logic [TS_W-1:0]  q_head;
  logic             q_full, q_empty;
  logic [CNT_W-1:0] q_count;
  logic             drop_evt;

  ts_capture u_cap (
    .time_now (time_now),
    .det_corr (det_corr),
    .det_rise (det_rise),
    .det_fall (det_fall),
    .push_req (push_req),
    .push_word(push_word)
  );

  ts_fifo #(.W(TS_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .push     (push_req),
    .push_data(push_word),
    .pop      (pop_req),
    .head     (q_head),
    .full     (q_full),
    .empty    (q_empty),
    .count    (q_count)
  );

  ts_drain #(.W(TS_W)) u_drain (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .q_empty    (q_empty),
    .q_head     (q_head),
    .pop_req    (pop_req),
    .ts_out     (ts_out),
    .ts_valid   (ts_valid)
  );

  assign drop_evt = push_req && q_full;
  assign full_dbg = {DBG_W{q_full}};

  always_ff @(posedge clk) begin
    if (rst)           ovf <= 1'b0;
    else if (drop_evt) ovf <= 1'b1;
  end
endmodule

// File: rtl/det_ts_queue_chk.sv
module det_ts_queue_chk #(
  parameter int DEPTH = 16,
  parameter int DBG_W = 8,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_start,
  input logic             push_req,
  input logic             q_full,
  input logic             q_empty,
  input logic [CNT_W-1:0] q_count,
  input logic [63:0]      ts_out,
  input logic             ts_valid,
  input logic [DBG_W-1:0] full_dbg,
  input logic             ovf
);
  assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (rst)
    ts_valid |-> (ts_out[60] == 1'b0));

  assert_pop_valid_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !q_empty) |=> ts_valid);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(ts_out) && $stable(ts_valid)));

  assert_dbg_ones_R6: assert property (@(posedge clk) disable iff (rst)
    (q_count == CNT_W'(DEPTH)) |-> (&full_dbg));

  assert_dbg_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (q_count != CNT_W'(DEPTH)) |-> (full_dbg == '0));

  assert_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (push_req && q_full && !frame_start) |=> q_full);

  assert_ovf_set_R7: assert property (@(posedge clk) disable iff (rst)
    (push_req && q_full) |=> ovf);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  assert_empty_repeat_R9: assert property (@(posedge clk) disable iff (rst)
    (frame_start && q_empty) |=> (!ts_valid && $stable(ts_out)));

  always @(posedge clk) begin
    if (!rst) begin
      assert_count_bound_R5: assert (q_count <= CNT_W'(DEPTH));
    end
  end
endmodule

bind det_ts_queue det_ts_queue_chk #(
  .DEPTH(DEPTH), .DBG_W(DBG_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .frame_start(frame_start),
  .push_req   (push_req),
  .q_full     (q_full),
  .q_empty    (q_empty),
  .q_count    (q_count),
  .ts_out     (ts_out),
  .ts_valid   (ts_valid),
  .full_dbg   (full_dbg),
  .ovf        (ovf)
);

// File: tb/test_det_ts_queue.sv
module test_det_ts_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int DBG_W = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] time_now = 64'hF000_0000_0000_1000;
  logic        det_corr = 1'b0, det_rise = 1'b0, det_fall = 1'b0;
  logic        frame_start = 1'b0;
  logic [63:0] ts_out;
  logic        ts_valid;
  logic [DBG_W-1:0] full_dbg;
  logic        ovf;

  int tests = 0;
  int fails = 0;

  logic [63:0] exp_q[$];
  logic [63:0] exp_out = '0;
  logic        exp_valid = 1'b0;
  logic        m_full, m_empty;
  logic [63:0] m_entry;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) time_now <= time_now + 64'd1;

  det_ts_queue #(.DEPTH(DEPTH), .DBG_W(DBG_W)) i_det_ts_queue (
    .clk(clk), .rst(rst), .time_now(time_now),
    .det_corr(det_corr), .det_rise(det_rise), .det_fall(det_fall),
    .frame_start(frame_start), .ts_out(ts_out), .ts_valid(ts_valid),
    .full_dbg(full_dbg), .ovf(ovf)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, cleared just after the edge.
  task automatic step(input logic c, input logic r, input logic f, input logic fs);
    @(negedge clk);
    det_corr = c; det_rise = r; det_fall = f; frame_start = fs;
    @(posedge clk);
    #1;
    det_corr = 1'b0; det_rise = 1'b0; det_fall = 1'b0; frame_start = 1'b0;
  endtask

  // Scoreboard model and monitor: R1 R2 R3 build the entry, R4 R9 drain, R7 drop.
  always @(posedge clk) begin
    if (!rst) begin
      m_full  = (exp_q.size() == DEPTH);
      m_empty = (exp_q.size() == 0);
      m_entry = {det_fall, det_rise, det_corr, 1'b0, time_now[59:0]};
      if (frame_start) begin
        if (!m_empty) begin
          exp_out   = exp_q.pop_front();
          exp_valid = 1'b1;
        end else begin
          exp_valid = 1'b0;
        end
      end
      if ((det_corr || det_rise || det_fall) && !m_full) exp_q.push_back(m_entry);
      if (frame_start) begin
        #1;
        if (exp_valid) begin
          check("R4 valid", {63'd0, ts_valid}, 64'd1);
          check("R4 word (R1 R2 R3 content)", ts_out, exp_out);
        end else begin
          check("R9 valid low", {63'd0, ts_valid}, 64'd0);
          check("R9 word repeated", ts_out, exp_out);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check("R10 ts_out", ts_out, 64'd0);
    check("R10 ts_valid", {63'd0, ts_valid}, 64'd0);
    check("R10 full_dbg", {56'd0, full_dbg}, 64'd0);
    check("R10 ovf", {63'd0, ovf}, 64'd0);

    step(0, 0, 0, 1);              // R9 empty frame after reset
    step(1, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 1);   // R2 correlator
    step(0, 1, 0, 0); step(0, 0, 1, 0); step(1, 0, 1, 0);   // R2 rise, fall, merged
    step(0, 0, 0, 1); step(0, 0, 0, 1); step(0, 0, 0, 1);
    step(0, 0, 0, 1);              // R9 repeat last word

    // R4 ordering: burst of five then five frames
    step(1, 0, 0, 0); step(0, 1, 0, 0); step(1, 1, 1, 0); step(0, 0, 1, 0); step(0, 1, 1, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1);

    // R6 / R5: fill to 15, then 16
    for (int i = 0; i < 15; i++) step(i[0], ~i[0], i[1], 0);
    check("R6 dbg zero at 15", {56'd0, full_dbg}, 64'd0);
    check("R8 ovf still low", {63'd0, ovf}, 64'd0);
    step(0, 0, 1, 0);
    check("R6 dbg ones at 16", {56'd0, full_dbg}, {56'd0, {DBG_W{1'b1}}});
    step(1, 0, 0, 0);              // R7 dropped while full
    check("R7 ovf set", {63'd0, ovf}, 64'd1);
    check("R7 still full", {56'd0, full_dbg}, {56'd0, {DBG_W{1'b1}}});
    step(0, 1, 0, 1);              // R7 full plus pop: push dropped
    check("R7 dbg after pop", {56'd0, full_dbg}, 64'd0);
    for (int i = 0; i < 15; i++) step(0, 0, 0, 1);   // R5 drain intact
    check("R8 ovf sticky", {63'd0, ovf}, 64'd1);
    step(0, 0, 0, 1);              // R9 empty
    step(0, 1, 0, 1);              // R9 detection on empty frame waits
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    check("R9 queue left empty", {63'd0, ts_valid}, 64'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule